// File: doc/BRIEF.md
# Floating-Point Add Special-Value Resolver

This stage sits next to a double-precision floating-point adder and decides, for each add, whether the special-value rules take precedence over the adder's own sum. It sorts each operand into one of five groups: zero, finite, infinity, quiet NaN or signalling NaN. It then looks at how the two groups combine, at the rounding mode, and at the adder's exact-zero indication. From these it produces either the adder's raw sum or a substituted value. The magnitude addition, normalisation and overflow/underflow handling stay in the adder.

Each operand comes with a flag that marks it as converted from an integer. An integer zero counts as positive whatever its sign bit holds. The result, a flag that says a substitution was made, and an invalid-operation flag all appear one clock after a valid input. The registered outputs hold their values while no input is valid.

Operands use the 64-bit layout: the sign in bit 63, the exponent in bits 62..52 and the fraction in bits 51..0. Bit 51 is the quiet bit of a NaN. The rounding-mode input uses this encoding: 00 to nearest, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.

Top module: `fadd_special_resolver`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `result`, `override` and `invalid` update only in the cycle after `in_valid` was high, and they hold otherwise. After reset all outputs are 0.
- R2: If either operand is a NaN (exponent all ones, fraction non-zero), the result is that NaN with bit 51 forced to 1, and operand A is chosen when both are NaN. `invalid` is raised only if at least one operand is a signalling NaN, meaning bit 51 is 0.
- R3: Two infinities of opposite sign give the default quiet NaN 0xFFF8000000000000 with `invalid` high.
- R4: Two infinities of the same sign give that infinity, with `invalid` low.
- R5: An infinity added to a zero or a finite value returns the infinity bit for bit, with `invalid` low.
- R6: When the operands are not both zero and the adder flags an exact-zero sum, the result is +0 (0x0000000000000000) in modes 00, 10 and 11, and -0 (0x8000000000000000) in mode 01.
- R7: Two zeros of the same effective sign give a zero of that sign in every mode. Two zeros of opposite effective sign follow the mode rule of R6.
- R8: A zero operand whose integer-source flag is set counts as +0, even when its sign bit is 1.
- R9: With no NaN, no infinity, not both operands zero, and no exact-zero indication, `result` equals the adder's raw sum, and `override` and `invalid` are low.
- R10: `override` is high exactly when one of the cases in R2 to R8 applies, and `invalid` never appears without `override`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and adder result are valid this cycle |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| a_from_int | input | 1 | Operand A was converted from an integer |
| b_from_int | input | 1 | Operand B was converted from an integer |
| rnd_mode | input | 2 | Rounding mode (00 near, 01 down, 10 up, 11 toward zero) |
| raw_sum | input | 64 | Adder's unresolved result |
| raw_zero | input | 1 | Adder reports an exact-zero sum |
| out_valid | output | 1 | Registered outputs hold a new decision |
| result | output | 64 | Final sum |
| override | output | 1 | Special-value rule replaced the raw sum |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Operands are drawn from a weighted mix of signed zeros, infinities, quiet and signalling NaNs and random finite values. This makes every pairing of groups appear many times, and it separates the order of the checks: NaN first, then infinity, then both zero, then exact zero. The integer-source flags and the rounding mode are randomised on their own. A zero sign that comes out wrong in any mode, or with either flag, therefore shows up at `result`. Directed pairs pin the default NaN, NaN choice when both operands are NaN, quieting of a signalling NaN, and the -0 that appears only in mode 01. Idle cycles with changing inputs show whether the registered outputs hold.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_FIN  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } opcls_e;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_DOWN  = 2'b01,
    RM_UP    = 2'b10,
    RM_TRUNC = 2'b11
  } rmode_e;

  function automatic logic cls_is_nan(opcls_e c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction
endpackage

// File: rtl/fsr_classify.sv
module fsr_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] opnd,
  input  logic                  from_int,
  output fsr_pkg::opcls_e       cls,
  output logic                  sign_eff
);
  import fsr_pkg::*;
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_zero, frac_zero;

  assign expo      = opnd[W-2:FRAC_W];
  assign frac      = opnd[FRAC_W-1:0];
  assign exp_ones  = &expo;
  assign exp_zero  = ~|expo;
  assign frac_zero = ~|frac;

  always_comb begin
    if (exp_ones) begin
      if (frac_zero)             cls = CLS_INF;
      else if (frac[FRAC_W-1])   cls = CLS_QNAN;
      else                       cls = CLS_SNAN;
    end else if (exp_zero && frac_zero) begin
      cls = CLS_ZERO;
    end else begin
      cls = CLS_FIN;
    end
  end

  // an integer-derived zero is always positive
  assign sign_eff = (from_int && cls == CLS_ZERO) ? 1'b0 : opnd[W-1];
endmodule

// File: rtl/fsr_decide.sv
module fsr_decide #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  fsr_pkg::opcls_e       cls_a,
  input  fsr_pkg::opcls_e       cls_b,
  input  logic                  sgn_a,
  input  logic                  sgn_b,
  input  logic [1:0]            rnd_mode,
  input  logic [EXP_W+FRAC_W:0] raw_sum,
  input  logic                  raw_zero,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  ovr,
  output logic                  inv,
  output logic                  ev_nan,
  output logic                  ev_inf_clash,
  output logic                  ev_zero_rule
);
  import fsr_pkg::*;
  localparam int W = 1 + EXP_W + FRAC_W;

  function automatic logic [W-1:0] quieten(logic [W-1:0] x);
    logic [W-1:0] y;
    y = x;
    y[FRAC_W-1] = 1'b1;
    return y;
  endfunction

  function automatic logic [W-1:0] default_nan();
    return {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction

  function automatic logic [W-1:0] zero_of(logic s);
    return {s, {(W-1){1'b0}}};
  endfunction

  logic nan_a, nan_b, inf_a, inf_b, both_zero, mode_down;

  assign nan_a     = cls_is_nan(cls_a);
  assign nan_b     = cls_is_nan(cls_b);
  assign inf_a     = (cls_a == CLS_INF);
  assign inf_b     = (cls_b == CLS_INF);
  assign both_zero = (cls_a == CLS_ZERO) && (cls_b == CLS_ZERO);
  assign mode_down = (rnd_mode == RM_DOWN);

  assign ev_nan       = nan_a | nan_b;
  assign ev_inf_clash = !ev_nan && inf_a && inf_b && (op_a[W-1] != op_b[W-1]);
  assign ev_zero_rule = !ev_nan && !inf_a && !inf_b && (both_zero || raw_zero);

  always_comb begin
    res = raw_sum;
    ovr = 1'b0;
    inv = 1'b0;
    if (ev_nan) begin
      ovr = 1'b1;
      inv = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
      res = nan_a ? quieten(op_a) : quieten(op_b);
    end else if (inf_a && inf_b) begin
      ovr = 1'b1;
      if (ev_inf_clash) begin
        inv = 1'b1;
        res = default_nan();
      end else begin
        res = op_a;
      end
    end else if (inf_a) begin
      ovr = 1'b1;
      res = op_a;
    end else if (inf_b) begin
      ovr = 1'b1;
      res = op_b;
    end else if (both_zero) begin
      ovr = 1'b1;
      res = zero_of((sgn_a == sgn_b) ? sgn_a : mode_down);
    end else if (raw_zero) begin
      ovr = 1'b1;
      res = zero_of(mode_down);
    end
  end
endmodule

// File: rtl/fadd_special_resolver.sv
module fadd_special_resolver #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic                  a_from_int,
  input  logic                  b_from_int,
  input  logic [1:0]            rnd_mode,
  input  logic [EXP_W+FRAC_W:0] raw_sum,
  input  logic                  raw_zero,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  override,
  output logic                  invalid
);
  import fsr_pkg::*;
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int N_OPS = 2;

  logic [W-1:0] opnd     [N_OPS];
  logic         from_int [N_OPS];
  opcls_e       cls      [N_OPS];
  logic         sgn      [N_OPS];

  assign opnd[0]     = op_a;
  assign opnd[1]     = op_b;
  assign from_int[0] = a_from_int;
  assign from_int[1] = b_from_int;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fsr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .opnd     (opnd[g]),
      .from_int (from_int[g]),
      .cls      (cls[g]),
      .sign_eff (sgn[g])
    );
  end

  logic [W-1:0] res_d;
  logic         ovr_d, inv_d;
  logic         ev_nan, ev_inf_clash, ev_zero_rule;

  fsr_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
    .op_a         (op_a),
    .op_b         (op_b),
    .cls_a        (cls[0]),
    .cls_b        (cls[1]),
    .sgn_a        (sgn[0]),
    .sgn_b        (sgn[1]),
    .rnd_mode     (rnd_mode),
    .raw_sum      (raw_sum),
    .raw_zero     (raw_zero),
    .res          (res_d),
    .ovr          (ovr_d),
    .inv          (inv_d),
    .ev_nan       (ev_nan),
    .ev_inf_clash (ev_inf_clash),
    .ev_zero_rule (ev_zero_rule)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      override  <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= res_d;
        override <= ovr_d;
        invalid  <= inv_d;
      end
    end
  end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int W      = 64,
  parameter int FRAC_W = 52
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] raw_sum,
  input logic         ev_any,
  input logic         ev_inf_clash,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         override,
  input logic         invalid
);
  localparam logic [W-1:0] DNAN = {2'b11, {(W-FRAC_W-1){1'b1}}, {(FRAC_W-1){1'b0}}} ;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(override) && $stable(invalid));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && invalid |-> (&result[W-2:FRAC_W-1]));

  assert_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ev_inf_clash |=> invalid && result == DNAN);

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ev_any |=> !override && !invalid && result == $past(raw_sum));

  assert_inv_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> override);
endmodule

bind fadd_special_resolver fsr_checker #(.W(W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .raw_sum      (raw_sum),
  .ev_any       (ovr_d),
  .ev_inf_clash (ev_inf_clash),
  .out_valid    (out_valid),
  .result       (result),
  .override     (override),
  .invalid      (invalid)
);

// File: tb/fadd_special_resolver_tb.sv
module fadd_special_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0, raw_sum = '0;
  logic        a_from_int = 1'b0, b_from_int = 1'b0, raw_zero = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        out_valid, override, invalid;
  logic [63:0] result;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fadd_special_resolver u_dut (.*);

  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] DNAN = 64'hFFF8_0000_0000_0000;

  function automatic bit f_nan(logic [63:0] x);  return x[62:52] == 11'h7FF && x[51:0] != 0; endfunction
  function automatic bit f_snan(logic [63:0] x); return f_nan(x) && !x[51]; endfunction
  function automatic bit f_inf(logic [63:0] x);  return x[62:0] == PINF[62:0]; endfunction
  function automatic bit f_zero(logic [63:0] x); return x[62:0] == 63'd0; endfunction

  // returns {override, invalid, result}
  function automatic logic [65:0] model(logic [63:0] a, logic [63:0] b, bit ai, bit bi,
                                        logic [1:0] rm, logic [63:0] rs, bit rz);
    bit sa, sb;
    if (f_nan(a) || f_nan(b)) begin
      logic [63:0] p;
      p = f_nan(a) ? a : b;
      return {1'b1, f_snan(a) || f_snan(b), p | 64'h0008_0000_0000_0000};
    end
    if (f_inf(a) && f_inf(b))
      return (a == b) ? {2'b10, a} : {2'b11, DNAN};
    if (f_inf(a)) return {2'b10, a};
    if (f_inf(b)) return {2'b10, b};
    if (f_zero(a) && f_zero(b)) begin
      sa = ai ? 1'b0 : a[63];
      sb = bi ? 1'b0 : b[63];
      return {2'b10, (sa == sb) ? sa : (rm == 2'b01), 63'd0};
    end
    if (rz) return {2'b10, rm == 2'b01, 63'd0};
    return {2'b00, rs};
  endfunction

  task automatic check(bit ok, string req, logic [65:0] act, logic [65:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual ovr/inv/res=%b/%b/%h expected %b/%b/%h",
               req, act[65], act[64], act[63:0], exp[65], exp[64], exp[63:0]);
    end
  endtask

  // drive one valid add at negedge, compare at the following negedge
  task automatic run(logic [63:0] a, logic [63:0] b, bit ai, bit bi, logic [1:0] rm,
                     logic [63:0] rs, bit rz, string req);
    logic [65:0] e;
    op_a = a; op_b = b; a_from_int = ai; b_from_int = bi;
    rnd_mode = rm; raw_sum = rs; raw_zero = rz; in_valid = 1'b1;
    e = model(a, b, ai, bi, rm, rs, rz);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {override, invalid, result} == e, req, {override, invalid, result}, e);
  endtask

  function automatic logic [63:0] pick_op();
    int k;
    logic [63:0] r;
    k = $urandom_range(0, 9);
    r = {$urandom, $urandom};
    case (k)
      0, 1: return {r[63], 63'd0};
      2, 3: return {r[63], 11'h7FF, 52'd0};
      4:    return {r[63], 11'h7FF, 1'b1, r[50:0]};
      5:    return {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
      default: return (r[62:52] == 11'h7FF) ? {r[63], 11'h3FF, r[51:0]} : r;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !override && !invalid && result == 0, "R1 reset",
          {override, invalid, result}, 66'd0);

    run(PINF, NINF, 0, 0, 2'b00, 64'h1234, 0, "R3 inf clash");
    run(NINF, NINF, 0, 0, 2'b01, 64'h1234, 0, "R4 same-sign inf");
    run(PINF, 64'h3FF0_0000_0000_0000, 0, 0, 2'b00, 64'h5, 0, "R5 inf+finite");
    run(NZ, NINF, 0, 0, 2'b11, 64'h5, 0, "R5 zero+inf");
    run(64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0002, 0, 0, 2'b00, 0, 0, "R2 snan A quieted");
    run(64'h7FF8_0000_0000_00AA, 64'h7FF8_0000_0000_00BB, 0, 0, 2'b00, 0, 0, "R2 A chosen");
    run(64'h3FF0_0000_0000_0000, 64'hFFF4_0000_0000_0000, 0, 0, 2'b00, 0, 0, "R2 snan B");
    run(64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0, 0, 2'b00, 64'h77, 1, "R6 near +0");
    run(64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0, 0, 2'b01, 64'h77, 1, "R6 down -0");
    run(64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0, 0, 2'b11, 64'h77, 1, "R6 trunc +0");
    run(NZ, NZ, 0, 0, 2'b00, 64'h9, 0, "R7 -0 + -0");
    run(PZ, NZ, 0, 0, 2'b01, 64'h9, 0, "R7 opposite zeros down");
    run(NZ, NZ, 1, 0, 2'b00, 64'h9, 0, "R8 int zero positive");
    run(NZ, NZ, 1, 1, 2'b01, 64'h9, 0, "R8 both int zeros");
    run(64'h4000_0000_0000_0000, PZ, 0, 0, 2'b10, 64'h4000_0000_0000_0000, 0, "R9 pass");
    run(64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0, 0, 2'b00, 64'h4008_0000_0000_0000, 0, "R10 no override");

    // R1 hold: inputs change with in_valid low, outputs must keep last decision
    begin
      logic [65:0] last;
      last = {override, invalid, result};
      op_a = PINF; op_b = NINF; raw_sum = 64'hDEAD; in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(!out_valid && {override, invalid, result} == last, "R1 hold",
            {override, invalid, result}, last);
    end

    process::self().srandom(32'd1234);
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a, b;
      a = pick_op();
      b = pick_op();
      run(a, b, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, 2'($urandom),
          {$urandom, $urandom}, $urandom_range(0, 4) == 0, "R2-R10 random mix");
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule